// File: doc/BRIEF.md
# Six-Channel PWM Pin Generator

This block drives six general-purpose output pins. Every pin can carry one of three sources: the LCD segment bit handed to it from the display logic, a static level held by the host, or a pulse-width modulated waveform. All six waveforms come from a single free-running 128-step counter. The counter moves forward by one step on each cycle where the one-cycle tick strobe is high, so the tick rate sets the PWM frame rate.

Each channel has its own 7-bit duty value. The fraction of a frame during which a PWM pin is high is the duty value divided by 128. Channels 0 to 2 and channels 3 to 5 are usually wired as two red-green-blue LED clusters.

When every waveform starts high at the same step, all LEDs switch on together and load the LED supply in one step. A global inversion control prevents this. It moves the high interval of the odd channels to the end of the frame, so their rising edges are spread out. To avoid glitch pulses, a new duty value or a new inversion setting is applied only at a frame boundary.

Top module: `pwm6_out_gen`

## Requirements
- R1: The frame counter advances by one, modulo 128, only on cycles where `tick_i` is 1. It holds its value on all other cycles. A synchronous `rst_i` returns it to 0.
- R2: With inversion off, a PWM pin is high exactly while the counter value is below the applied duty value. This gives a high fraction of duty/128.
- R3: An applied duty of 0 keeps the PWM waveform low for the whole frame, with inversion on or off.
- R4: The pin mode is the 2-bit field `mode_i[2i+1:2i]`. Mode values 00 and 01 both pass `seg_i[i]` to `pin_o[i]` in the same cycle.
- R5: Mode 10 drives `gpo_lvl_i[i]` onto the pin in the same cycle.
- R6: Mode 11 drives channel i's PWM waveform onto the pin.
- R7: A duty value written on `duty_i[7i+6:7i]` and the `invert_i` level are both sampled only on the tick at which the counter wraps from 127 to 0. They govern the waveform from the next frame onward.
- R8: With the applied inversion on, even channels keep the R2 waveform. An odd channel is high while the counter is at or above 128 minus its duty value.
- R9: With inversion off, every channel whose duty is nonzero is high at counter value 0, so all such channels rise together at the start of a frame.
- R10: After reset, the counter is 0, every applied duty is 0 and the applied inversion is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle strobe that advances the frame counter |
| duty_i | input | 42 | Six 7-bit duty values; channel i in bits 7i+6:7i |
| mode_i | input | 12 | Six 2-bit pin modes; pin i in bits 2i+1:2i |
| gpo_lvl_i | input | 6 | Static level for each pin in mode 10 |
| seg_i | input | 6 | LCD segment bit for each pin in modes 00/01 |
| invert_i | input | 1 | Requested inversion (edge staggering) setting |
| pin_o | output | 6 | Pin values |

## Verification
On every cycle, assertions check the following:
- The counter holds or steps as R1 requires.
- The applied duty and the applied inversion stay stable between frame wraps.
- A zero duty never produces a high level.
- Nonzero channels are high at step 0 when inversion is off.
- Staggered odd channels are high on the last step of the frame.
- Each pin follows the source that its mode selects.

The bench scenarios cover what a single-cycle property cannot show. They check the full waveform shape across whole frames for several duty sets, including 1 and 127. They show that a mid-frame duty or inversion change waits for the wrap. They also cover tick gaps, a reset in the middle of a run, and mixed modes across pins.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
  typedef enum logic [1:0] {
    PM_SEG_A = 2'b00,
    PM_SEG_B = 2'b01,
    PM_GPO   = 2'b10,
    PM_PWM   = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = '1;

  // the tick that moves the counter from its last step back to 0
  assign wrap_o = tick_i && (cnt_o == LAST);

  always_ff @(posedge clk) begin
    if (rst_i)       cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  // R1: no tick, no movement
  a_r1_hold: assert property (@(posedge clk) disable iff (rst_i)
    !tick_i |=> $stable(cnt_o));
  // R1: a tick moves exactly one step, wrapping modulo the frame length
  a_r1_step: assert property (@(posedge clk) disable iff (rst_i)
    tick_i |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int DUTY_W  = 7,
  parameter bit STAGGER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              wrap_i,
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              inv_i,
  output logic              wave_o
);
  localparam int EW = DUTY_W + 1;
  localparam logic [EW-1:0]     PERIOD_EXT = {1'b1, {DUTY_W{1'b0}}};
  localparam logic [DUTY_W-1:0] LAST = '1;

  logic [DUTY_W-1:0] act_duty;
  logic              late;

  // Early form: high from step 0 up to duty-1.
  // Late form: high for the final 'duty' steps of the frame.
  function automatic logic level_at(input logic [DUTY_W-1:0] c,
                                    input logic [DUTY_W-1:0] d,
                                    input logic              late_form);
    if (late_form) return ({1'b0, c} >= (PERIOD_EXT - {1'b0, d}));
    else           return (c < d);
  endfunction

  always_ff @(posedge clk) begin
    if (rst_i)       act_duty <= '0;
    else if (wrap_i) act_duty <= duty_i;
  end

  assign late   = STAGGER && inv_i;
  assign wave_o = level_at(cnt_i, act_duty, late);

  // R7: applied duty changes only at a frame wrap
  a_r7_duty_hold: assert property (@(posedge clk) disable iff (rst_i)
    !wrap_i |=> $stable(act_duty));
  // R3: zero duty never drives high
  a_r3_zero_low: assert property (@(posedge clk) disable iff (rst_i)
    (act_duty == '0) |-> !wave_o);
  // R9: early-form channels with nonzero duty are high at step 0
  a_r9_start_high: assert property (@(posedge clk) disable iff (rst_i)
    (!late && act_duty != '0 && cnt_i == '0) |-> wave_o);
  // R8: late-form channels with nonzero duty are high on the final step
  a_r8_late_tail: assert property (@(posedge clk) disable iff (rst_i)
    (late && act_duty != '0 && cnt_i == LAST) |-> wave_o);
endmodule

// File: rtl/pin_mode_mux.sv
module pin_mode_mux #(
  parameter int NUM_CH = 6
) (
  input  logic [2*NUM_CH-1:0] mode_i,
  input  logic [NUM_CH-1:0]   seg_i,
  input  logic [NUM_CH-1:0]   gpo_lvl_i,
  input  logic [NUM_CH-1:0]   wave_i,
  output logic [NUM_CH-1:0]   pin_o
);
  import pwmgen_pkg::*;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
    pin_mode_e sel;
    assign sel = pin_mode_e'(mode_i[2*i +: 2]);
    always_comb begin
      case (sel)
        PM_GPO:  pin_o[i] = gpo_lvl_i[i];
        PM_PWM:  pin_o[i] = wave_i[i];
        default: pin_o[i] = seg_i[i];
      endcase
    end
  end
endmodule

// File: rtl/pwm6_out_gen.sv
module pwm6_out_gen #(
  parameter int NUM_CH = 6,
  parameter int DUTY_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_i,
  input  logic                     tick_i,
  input  logic [NUM_CH*DUTY_W-1:0] duty_i,
  input  logic [2*NUM_CH-1:0]      mode_i,
  input  logic [NUM_CH-1:0]        gpo_lvl_i,
  input  logic [NUM_CH-1:0]        seg_i,
  input  logic                     invert_i,
  output logic [NUM_CH-1:0]        pin_o
);
  logic [DUTY_W-1:0] frame_cnt;
  logic              frame_wrap;
  logic              inv_act;
  logic [NUM_CH-1:0] wave;

  pwm_period_counter #(.CNT_W(DUTY_W)) u_cnt (
    .clk    (clk),
    .rst_i  (rst_i),
    .tick_i (tick_i),
    .cnt_o  (frame_cnt),
    .wrap_o (frame_wrap)
  );

  // inversion is applied only at the frame boundary, like the duties
  always_ff @(posedge clk) begin
    if (rst_i)           inv_act <= 1'b0;
    else if (frame_wrap) inv_act <= invert_i;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_channel #(.DUTY_W(DUTY_W), .STAGGER(i % 2 == 1)) u_ch (
      .clk    (clk),
      .rst_i  (rst_i),
      .wrap_i (frame_wrap),
      .cnt_i  (frame_cnt),
      .duty_i (duty_i[DUTY_W*i +: DUTY_W]),
      .inv_i  (inv_act),
      .wave_o (wave[i])
    );

    // R4 / R5 / R6: each pin follows the source its mode field selects
    a_r4_seg_pass: assert property (@(posedge clk) disable iff (rst_i)
      (mode_i[2*i+1] == 1'b0) |-> (pin_o[i] == seg_i[i]));
    a_r5_gpo_pass: assert property (@(posedge clk) disable iff (rst_i)
      (mode_i[2*i +: 2] == 2'b10) |-> (pin_o[i] == gpo_lvl_i[i]));
    a_r6_pwm_pass: assert property (@(posedge clk) disable iff (rst_i)
      (mode_i[2*i +: 2] == 2'b11) |-> (pin_o[i] == wave[i]));
  end

  pin_mode_mux #(.NUM_CH(NUM_CH)) u_mux (
    .mode_i    (mode_i),
    .seg_i     (seg_i),
    .gpo_lvl_i (gpo_lvl_i),
    .wave_i    (wave),
    .pin_o     (pin_o)
  );

  // R7: applied inversion changes only at a frame wrap
  a_r7_inv_hold: assert property (@(posedge clk) disable iff (rst_i)
    !frame_wrap |=> $stable(inv_act));
endmodule

// File: tb/tb_pwm6_out_gen.sv
module tb_pwm6_out_gen;
  localparam int N = 6;
  localparam int W = 7;

  logic           clk = 1'b0;
  logic           rst_i = 1'b1;
  logic           tick_i = 1'b0;
  logic [N*W-1:0] duty_i = '0;
  logic [2*N-1:0] mode_i = '0;
  logic [N-1:0]   gpo_lvl_i = '0;
  logic [N-1:0]   seg_i = '0;
  logic           invert_i = 1'b0;
  logic [N-1:0]   pin_o;

  always #5 clk = ~clk;

  pwm6_out_gen dut (
    .clk(clk), .rst_i(rst_i), .tick_i(tick_i), .duty_i(duty_i),
    .mode_i(mode_i), .gpo_lvl_i(gpo_lvl_i), .seg_i(seg_i),
    .invert_i(invert_i), .pin_o(pin_o)
  );

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur_tag = "R10";

  // independent model state
  int           m_cnt = 0;
  logic [W-1:0] m_duty [N];
  bit           m_inv = 0;

  function automatic logic model_wave(int ch);
    int d = int'(m_duty[ch]);
    if (m_inv && (ch % 2 == 1)) return (m_cnt + d) > 127;
    return m_cnt < d;
  endfunction

  function automatic logic [N-1:0] model_pins();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (mode_i[2*i +: 2])
        2'b10:   r[i] = gpo_lvl_i[i];
        2'b11:   r[i] = model_wave(i);
        default: r[i] = seg_i[i];
      endcase
    end
    return r;
  endfunction

  // driver: one cycle, then push the expected pin vector
  task automatic step(input bit tk);
    item_t it;
    tick_i = tk;
    @(posedge clk);
    if (tk) begin
      if (m_cnt == 127) begin
        for (int i = 0; i < N; i++) m_duty[i] = duty_i[W*i +: W];
        m_inv = invert_i;
      end
      m_cnt = (m_cnt + 1) % 128;
    end
    it.exp = model_pins();
    it.tag = cur_tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step(1'b1);
  endtask

  task automatic do_reset();
    rst_i  = 1'b1;
    tick_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_i = 1'b0;
    m_cnt = 0;
    m_inv = 0;
    for (int i = 0; i < N; i++) m_duty[i] = '0;
  endtask

  task automatic set_duties(input int a, input int b, input int c,
                            input int d, input int e, input int f);
    duty_i = {W'(f), W'(e), W'(d), W'(c), W'(b), W'(a)};
  endtask

  // monitor: compares away from the clock edge
  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (pin_o !== it.exp) begin
        errors++;
        $display("FAIL %s pins=%b expected=%b at t=%0t", it.tag, pin_o, it.exp, $time);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired (no requirement) actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_duty[i] = '0;
    @(negedge clk);
    do_reset();

    // R10 / R4: reset state; modes 00 pass the segment bits
    cur_tag = "R10 reset";
    seg_i = 6'b101101;
    step(1'b0);
    cur_tag = "R4 lcd";
    mode_i = {N{2'b01}};
    step(1'b0);
    seg_i = 6'b010010;
    step(1'b0);

    // R5: static levels
    cur_tag = "R5 gpo";
    mode_i = {N{2'b10}};
    gpo_lvl_i = 6'b110011;
    step(1'b0);
    gpo_lvl_i = 6'b001101;
    step(1'b1);

    // R7: first frame still runs on the reset duties (all low)
    cur_tag = "R7 first frame";
    mode_i = {N{2'b11}};
    set_duties(0, 1, 32, 64, 96, 127);
    run(127);
    // R2 / R6 / R9 / R3 over two whole frames
    cur_tag = "R2 R6 R9 R3 frames";
    run(256);

    // R7: change mid-frame, old duties stay until the wrap
    cur_tag = "R7 mid-frame change";
    run(50);
    set_duties(5, 127, 0, 100, 64, 2);
    run(200);

    // R8 / R3: inversion with an odd zero-duty channel
    cur_tag = "R8 R3 invert";
    set_duties(3, 0, 10, 40, 127, 1);
    invert_i = 1'b1;
    run(400);

    // R1: ticks with gaps
    cur_tag = "R1 tick gaps";
    for (int k = 0; k < 60; k++) begin
      step(1'b1);
      step(1'b0);
      step(1'b0);
    end

    // R1 / R10: synchronous reset in the middle of a frame
    cur_tag = "R1 R10 mid reset";
    do_reset();
    step(1'b0);
    invert_i = 1'b0;
    set_duties(64, 64, 64, 64, 64, 64);
    run(260);

    // R4 / R5 / R6: mixed modes across pins
    cur_tag = "R4 R5 R6 mixed";
    mode_i = {2'b11, 2'b10, 2'b00, 2'b11, 2'b01, 2'b10};
    seg_i = 6'b111000;
    gpo_lvl_i = 6'b010101;
    run(140);

    @(posedge clk);
    #4;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule